// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the eight-bit status word of a small accumulator CPU. Each cycle it can take flag results from the ALU and operand bits from a bit-test instruction. It also responds to the decoded flag-control commands: page select, interrupt enable and disable, clear overflow, software break and interrupt acknowledge. It can also overwrite the whole word at once, as when the word is restored from the stack. Each flag changes only when its own update strobe or command is active. All other flags keep their value.

The registered page flag also drives the high byte of the direct-addressing window. That byte selects either the bottom 256-byte page or the page above it. The ALU, the decoder, the stacking of the word and interrupt vectoring all live outside this block.

Top module: `status_word_reg`

## Requirements
- R1: After reset is asserted, `statusWord` reads 00h and `pageHigh` reads 00h.
- R2: The word layout from bit 7 down to bit 0 is: negative, overflow, page, break, half-carry, interrupt-enable, zero, carry. With `loadWord` high, all eight bits take `loadData` at the next edge, whatever else is asserted.
- R3: Bit 7 takes `memOperand[7]` when `bitTest` is high. Otherwise it takes `aluResult[7]` when `updN` is high.
- R4: `cmdClrOvf` clears bit 6 and bit 3 together, and it beats every other source for those bits. Otherwise bit 6 takes `memOperand[6]` on `bitTest`, or `aluOverflow` on `updV`. No command sets bit 6.
- R5: When `updH` is high and `cmdClrOvf` is low, bit 3 takes `aluCarry3` if `opIsSub` is 0, or `aluNoBorrow4` if `opIsSub` is 1.
- R6: Bit 1 is set to (`aluResult` == 0) when `updZ` is high. Bit 0 takes `aluCarry` when `updC` is high.
- R7: `cmdSetPage` sets bit 5 and `cmdClrPage` clears it; the clear wins if both are high. `pageHigh` always equals {0…0, bit 5}.
- R8: `cmdIntEnable` sets bit 2. `cmdIntDisable` or `intAck` clears it, and a clear wins over the set.
- R9: `cmdBreak` sets bit 4. Apart from reset and a word load, nothing clears it.
- R10: In a cycle with no load, no strobe and no command, the word does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| aluResult | input | 8 | ALU result byte |
| aluCarry | input | 1 | ALU carry out of bit 7 |
| aluCarry3 | input | 1 | Carry out of ALU bit 3 (addition) |
| aluNoBorrow4 | input | 1 | No borrow from ALU bit 4 (subtraction) |
| aluOverflow | input | 1 | Signed overflow of the ALU result |
| opIsSub | input | 1 | Current ALU operation is a subtraction |
| updN | input | 1 | Operation affects the negative flag |
| updV | input | 1 | Operation affects the overflow flag |
| updH | input | 1 | Operation affects the half-carry flag |
| updZ | input | 1 | Operation affects the zero flag |
| updC | input | 1 | Operation affects the carry flag |
| bitTest | input | 1 | Bit-test instruction in progress |
| memOperand | input | 8 | Memory operand of the bit-test |
| cmdSetPage | input | 1 | Select the upper direct page |
| cmdClrPage | input | 1 | Select the lower direct page |
| cmdIntEnable | input | 1 | Enable interrupts |
| cmdIntDisable | input | 1 | Disable interrupts |
| cmdClrOvf | input | 1 | Clear overflow and half-carry |
| cmdBreak | input | 1 | Software break |
| intAck | input | 1 | Interrupt being serviced |
| loadWord | input | 1 | Load the whole word |
| loadData | input | 8 | Word to load |
| statusWord | output | 8 | Registered status word |
| pageHigh | output | 8 | High address byte of the direct page |

## Verification
The hardest cases to reach from the ports are the cycles where sources collide. Examples are a bit-test together with an overflow clear, an interrupt acknowledge on top of an enable, or a load on top of every strobe. Also, only a non-zero starting word shows whether a clear really acted. The stimulus therefore first loads known words such as FFh, 00h and A5h. From each one it sweeps all 128 combinations of the seven commands. It follows this with random vectors where every strobe is independent, so that collisions are frequent. Every vector is compared with a next-word model computed from the requirements.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int WORD_W = 8;

  // Bit positions in the status word (order is architectural)
  localparam int B_NEG  = 7;
  localparam int B_OVF  = 6;
  localparam int B_PAGE = 5;
  localparam int B_BRK  = 4;
  localparam int B_HALF = 3;
  localparam int B_IEN  = 2;
  localparam int B_ZERO = 1;
  localparam int B_CARRY = 0;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadAll;
    logic nWe;
    logic nFromMem;
    logic vWe;
    logic vClr;
    logic vFromMem;
    logic hWe;
    logic hClr;
    logic hSub;
    logic gSet;
    logic gClr;
    logic iSet;
    logic iClr;
    logic bSet;
    logic zWe;
    logic cWe;
  } psw_ctl_t;
endpackage

// File: rtl/psw_ctrl.sv
module psw_ctrl
  import psw_pkg::*;
(
  input  logic     updN,
  input  logic     updV,
  input  logic     updH,
  input  logic     updZ,
  input  logic     updC,
  input  logic     opIsSub,
  input  logic     bitTest,
  input  logic     cmdSetPage,
  input  logic     cmdClrPage,
  input  logic     cmdIntEnable,
  input  logic     cmdIntDisable,
  input  logic     cmdClrOvf,
  input  logic     cmdBreak,
  input  logic     intAck,
  input  logic     loadWord,
  output psw_ctl_t ctl
);
  always_comb begin
    ctl          = '0;
    ctl.loadAll  = loadWord;
    // negative: bit-test operand has precedence over the ALU
    ctl.nWe      = bitTest | updN;
    ctl.nFromMem = bitTest;
    // overflow: clear command has precedence, then bit-test, then ALU
    ctl.vClr     = cmdClrOvf;
    ctl.vWe      = bitTest | updV;
    ctl.vFromMem = bitTest;
    // half carry shares the clear command with overflow
    ctl.hClr     = cmdClrOvf;
    ctl.hWe      = updH;
    ctl.hSub     = opIsSub;
    // page select: clear wins
    ctl.gClr     = cmdClrPage;
    ctl.gSet     = cmdSetPage & ~cmdClrPage;
    // interrupt enable: any clear source wins
    ctl.iClr     = cmdIntDisable | intAck;
    ctl.iSet     = cmdIntEnable & ~(cmdIntDisable | intAck);
    ctl.bSet     = cmdBreak;
    ctl.zWe      = updZ;
    ctl.cWe      = updC;
  end
endmodule

// File: rtl/psw_datapath.sv
module psw_datapath
  import psw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  psw_ctl_t          ctl,
  input  logic [WORD_W-1:0] aluResult,
  input  logic              aluCarry,
  input  logic              aluCarry3,
  input  logic              aluNoBorrow4,
  input  logic              aluOverflow,
  input  logic [WORD_W-1:0] memOperand,
  input  logic [WORD_W-1:0] loadData,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] flagNext;
  logic [WORD_W-1:0] flagWe;
  logic              resultZero;

  assign resultZero = (aluResult == '0);

  // per-flag next value and write enable
  always_comb begin
    flagNext = word;
    flagWe   = '0;

    flagWe[B_NEG]   = ctl.nWe;
    flagNext[B_NEG] = ctl.nFromMem ? memOperand[WORD_W-1] : aluResult[WORD_W-1];

    flagWe[B_OVF]   = ctl.vClr | ctl.vWe;
    flagNext[B_OVF] = ctl.vClr ? 1'b0 :
                      (ctl.vFromMem ? memOperand[WORD_W-2] : aluOverflow);

    flagWe[B_HALF]   = ctl.hClr | ctl.hWe;
    flagNext[B_HALF] = ctl.hClr ? 1'b0 : (ctl.hSub ? aluNoBorrow4 : aluCarry3);

    flagWe[B_PAGE]   = ctl.gSet | ctl.gClr;
    flagNext[B_PAGE] = ctl.gSet;

    flagWe[B_IEN]    = ctl.iSet | ctl.iClr;
    flagNext[B_IEN]  = ctl.iSet;

    flagWe[B_BRK]    = ctl.bSet;
    flagNext[B_BRK]  = 1'b1;

    flagWe[B_ZERO]   = ctl.zWe;
    flagNext[B_ZERO] = resultZero;

    flagWe[B_CARRY]   = ctl.cWe;
    flagNext[B_CARRY] = aluCarry;
  end

  // one storage cell per flag; full-word load overrides everything
  for (genvar i = 0; i < WORD_W; i++) begin : g_cell
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        word[i] <= 1'b0;
      else if (ctl.loadAll)
        word[i] <= loadData[i];
      else if (flagWe[i])
        word[i] <= flagNext[i];
    end
  end
endmodule

// File: rtl/status_word_reg.sv
module status_word_reg
  import psw_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] aluResult,
  input  logic              aluCarry,
  input  logic              aluCarry3,
  input  logic              aluNoBorrow4,
  input  logic              aluOverflow,
  input  logic              opIsSub,
  input  logic              updN,
  input  logic              updV,
  input  logic              updH,
  input  logic              updZ,
  input  logic              updC,
  input  logic              bitTest,
  input  logic [WORD_W-1:0] memOperand,
  input  logic              cmdSetPage,
  input  logic              cmdClrPage,
  input  logic              cmdIntEnable,
  input  logic              cmdIntDisable,
  input  logic              cmdClrOvf,
  input  logic              cmdBreak,
  input  logic              intAck,
  input  logic              loadWord,
  input  logic [WORD_W-1:0] loadData,
  output logic [WORD_W-1:0] statusWord,
  output logic [PAGE_W-1:0] pageHigh
);
  psw_ctl_t ctl;

  psw_ctrl u_ctrl (
    .updN(updN), .updV(updV), .updH(updH), .updZ(updZ), .updC(updC),
    .opIsSub(opIsSub), .bitTest(bitTest),
    .cmdSetPage(cmdSetPage), .cmdClrPage(cmdClrPage),
    .cmdIntEnable(cmdIntEnable), .cmdIntDisable(cmdIntDisable),
    .cmdClrOvf(cmdClrOvf), .cmdBreak(cmdBreak), .intAck(intAck),
    .loadWord(loadWord), .ctl(ctl)
  );

  psw_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .aluResult(aluResult), .aluCarry(aluCarry), .aluCarry3(aluCarry3),
    .aluNoBorrow4(aluNoBorrow4), .aluOverflow(aluOverflow),
    .memOperand(memOperand), .loadData(loadData), .word(statusWord)
  );

  assign pageHigh = {{(PAGE_W-1){1'b0}}, statusWord[B_PAGE]};
endmodule

// File: rtl/psw_checker.sv
module psw_checker #(
  parameter int PAGE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdClrOvf,
  input logic              cmdBreak,
  input logic              intAck,
  input logic              cmdClrPage,
  input logic              loadWord,
  input logic [7:0]        loadData,
  input logic              anyStrobe,
  input logic [7:0]        statusWord,
  input logic [PAGE_W-1:0] pageHigh
);
  a_r2_load_all: assert property (@(posedge clk) disable iff (!rstN)
    loadWord |=> statusWord == $past(loadData));

  a_r4_clr_ovf_half: assert property (@(posedge clk) disable iff (!rstN)
    (!loadWord && cmdClrOvf) |=> (!statusWord[6] && !statusWord[3]));

  a_r7_page_clear: assert property (@(posedge clk) disable iff (!rstN)
    (!loadWord && cmdClrPage) |=> pageHigh == '0);

  a_r8_ack_masks: assert property (@(posedge clk) disable iff (!rstN)
    (!loadWord && intAck) |=> !statusWord[2]);

  a_r9_break_sets: assert property (@(posedge clk) disable iff (!rstN)
    (!loadWord && cmdBreak) |=> statusWord[4]);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!loadWord && !anyStrobe) |=> $stable(statusWord));
endmodule

bind status_word_reg psw_checker #(.PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdClrOvf(cmdClrOvf), .cmdBreak(cmdBreak),
  .intAck(intAck), .cmdClrPage(cmdClrPage), .loadWord(loadWord),
  .loadData(loadData),
  .anyStrobe(updN | updV | updH | updZ | updC | bitTest | cmdSetPage |
             cmdClrPage | cmdIntEnable | cmdIntDisable | cmdClrOvf |
             cmdBreak | intAck),
  .statusWord(statusWord), .pageHigh(pageHigh)
);

// File: tb/sim_status_word_reg.sv
module sim_status_word_reg;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] aluResult = '0, memOperand = '0, loadData = '0;
  logic aluCarry = 0, aluCarry3 = 0, aluNoBorrow4 = 0, aluOverflow = 0, opIsSub = 0;
  logic updN = 0, updV = 0, updH = 0, updZ = 0, updC = 0, bitTest = 0;
  logic cmdSetPage = 0, cmdClrPage = 0, cmdIntEnable = 0, cmdIntDisable = 0;
  logic cmdClrOvf = 0, cmdBreak = 0, intAck = 0, loadWord = 0;
  logic [7:0] statusWord, pageHigh;

  int vecCount = 0;
  int errCount = 0;
  bit done = 0;
  logic [7:0] expW = '0;

  always #10 clk = ~clk;

  status_word_reg u0 (
    .clk(clk), .rstN(rstN), .aluResult(aluResult), .aluCarry(aluCarry),
    .aluCarry3(aluCarry3), .aluNoBorrow4(aluNoBorrow4), .aluOverflow(aluOverflow),
    .opIsSub(opIsSub), .updN(updN), .updV(updV), .updH(updH), .updZ(updZ),
    .updC(updC), .bitTest(bitTest), .memOperand(memOperand),
    .cmdSetPage(cmdSetPage), .cmdClrPage(cmdClrPage), .cmdIntEnable(cmdIntEnable),
    .cmdIntDisable(cmdIntDisable), .cmdClrOvf(cmdClrOvf), .cmdBreak(cmdBreak),
    .intAck(intAck), .loadWord(loadWord), .loadData(loadData),
    .statusWord(statusWord), .pageHigh(pageHigh)
  );

  // next word computed from the requirements
  function automatic logic [7:0] nextWord(input logic [7:0] cur);
    logic [7:0] r;
    r = cur;
    if (loadWord) return loadData;                                       // R2
    if (bitTest) r[7] = memOperand[7]; else if (updN) r[7] = aluResult[7]; // R3
    if (cmdClrOvf) r[6] = 1'b0;                                          // R4
    else if (bitTest) r[6] = memOperand[6];
    else if (updV) r[6] = aluOverflow;
    if (cmdClrOvf) r[3] = 1'b0;                                          // R5
    else if (updH) r[3] = opIsSub ? aluNoBorrow4 : aluCarry3;
    if (cmdClrPage) r[5] = 1'b0; else if (cmdSetPage) r[5] = 1'b1;       // R7
    if (cmdIntDisable || intAck) r[2] = 1'b0;                             // R8
    else if (cmdIntEnable) r[2] = 1'b1;
    if (cmdBreak) r[4] = 1'b1;                                           // R9
    if (updZ) r[1] = (aluResult == 8'h00);                               // R6
    if (updC) r[0] = aluCarry;
    return r;
  endfunction

  function automatic string bitReq(input int b);
    case (b)
      7: return "R3";
      6: return "R4";
      5: return "R7";
      4: return "R9";
      3: return "R5";
      2: return "R8";
      default: return "R6";
    endcase
  endfunction

  task automatic clearInputs();
    {updN, updV, updH, updZ, updC, bitTest} = '0;
    {cmdSetPage, cmdClrPage, cmdIntEnable, cmdIntDisable} = '0;
    {cmdClrOvf, cmdBreak, intAck, loadWord} = '0;
  endtask

  // inputs are already set (we are at a negedge); clock once and compare
  task automatic step(input string tag);
    logic [7:0] e;
    bit quiet;
    e = nextWord(expW);
    quiet = !(loadWord | updN | updV | updH | updZ | updC | bitTest | cmdSetPage |
              cmdClrPage | cmdIntEnable | cmdIntDisable | cmdClrOvf | cmdBreak | intAck);
    @(posedge clk);
    @(negedge clk);
    vecCount++;
    expW = e;
    if (statusWord !== e) begin
      errCount++;
      for (int b = 7; b >= 0; b--) begin
        if (statusWord[b] !== e[b]) begin
          $display("FAIL %s [%s] bit%0d word=%02h expected=%02h",
                   loadWord ? "R2" : (quiet ? "R10" : bitReq(b)), tag, b, statusWord, e);
          break;
        end
      end
    end
    if (pageHigh !== {7'b0, e[5]}) begin
      errCount++;
      $display("FAIL R7 [%s] pageHigh=%02h expected=%02h", tag, pageHigh, {7'b0, e[5]});
    end
    clearInputs();
  endtask

  task automatic loadTo(input logic [7:0] v);
    loadWord = 1'b1;
    loadData = v;
    step("R2 load");
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errCount++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    vecCount++;
    if (statusWord !== 8'h00 || pageHigh !== 8'h00) begin
      errCount++;
      $display("FAIL R1 reset word=%02h page=%02h expected=00/00", statusWord, pageHigh);
    end
    rstN = 1'b1;
    @(negedge clk);
    expW = 8'h00;

    // R2: every load value, with every other strobe asserted too
    for (int v = 0; v < 256; v++) begin
      {updN, updV, updH, updZ, updC, bitTest} = '1;
      {cmdSetPage, cmdClrPage, cmdIntEnable, cmdIntDisable, cmdClrOvf, cmdBreak, intAck} = '1;
      aluResult = 8'(v ^ 8'h5a);
      memOperand = 8'(~v);
      loadTo(8'(v));
    end

    // R3/R6: every result byte through N and Z, carry alternating
    for (int v = 0; v < 256; v++) begin
      aluResult = 8'(v); aluCarry = v[0];
      updN = 1; updZ = 1; updC = 1;
      step("R3 R6 result sweep");
    end

    // R3/R4: every memory operand through the bit-test, with ALU sources conflicting
    for (int v = 0; v < 256; v++) begin
      memOperand = 8'(v); aluResult = 8'(~v); aluOverflow = ~v[6];
      bitTest = 1; updN = v[1]; updV = v[2];
      step("R3 R4 bit-test sweep");
    end

    // R5/R6: half-carry and carry sources, all combinations
    for (int v = 0; v < 32; v++) begin
      {opIsSub, aluCarry3, aluNoBorrow4, aluCarry, aluOverflow} = 5'(v);
      updH = 1; updC = 1; updV = 1;
      step("R5 half-carry sweep");
    end

    // R4,R7,R8,R9: all command combinations from several start words
    foreach (expW[k]) begin end
    for (int s = 0; s < 3; s++) begin
      for (int c = 0; c < 128; c++) begin
        loadTo(s == 0 ? 8'hff : (s == 1 ? 8'h00 : 8'ha5));
        {cmdSetPage, cmdClrPage, cmdIntEnable, cmdIntDisable, cmdClrOvf, cmdBreak, intAck} = 7'(c);
        updH = c[0]; updV = c[1]; aluCarry3 = 1; aluOverflow = 1;
        step("R4 R7 R8 R9 command sweep");
      end
    end

    // R10: idle cycles from a loaded pattern
    loadTo(8'h96);
    for (int i = 0; i < 16; i++) begin
      aluResult = 8'(i * 37); memOperand = 8'(i * 11); aluCarry = 1; aluOverflow = 1;
      step("R10 idle");
    end

    // random mix with frequent collisions
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] r;
      r = $urandom;
      aluResult = r[7:0]; memOperand = r[15:8];
      {aluCarry, aluCarry3, aluNoBorrow4, aluOverflow, opIsSub} = r[20:16];
      r = $urandom;
      {updN, updV, updH, updZ, updC, bitTest} = r[5:0] & r[11:6];
      {cmdSetPage, cmdClrPage, cmdIntEnable, cmdIntDisable, cmdClrOvf, cmdBreak, intAck} =
        r[18:12] & r[25:19];
      loadWord = (r[31:28] == 4'h0);
      loadData = r[27:20];
      step("random mix");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end
endmodule